// File: doc/BRIEF.md
# Indexed Interrupt Configuration Unit

This block keeps per-line interrupt configuration and pending state for a small processor core and chooses which request to present to it. Software reaches every line through one narrow register window: it first stores a line number in a select register, and each later access to the enable, priority, trigger-mode or cancel register acts only on that line. The selection holds until the select register is written again.

Each raw interrupt input passes through a synchroniser. A line in level mode is pending for as long as its synchronised input is high. A line in pulse mode latches a flag on a rising edge. The flag clears when the core takes that line, or when software writes 1 to the cancel register. Among the lines that are pending and enabled, the one with the numerically lowest priority value wins, and the lower line number breaks ties. The winner is offered to the core only when its priority is more urgent than every level already in service. The active register tracks the levels in service: taking a line sets the bit for its priority, and a completion pulse clears the most urgent bit that is set.

Top module: `irq_cfg_unit`

## Requirements
- R1: The select register (address 0) names the line that addresses 1 to 4 act on. The selection stays in force until address 0 is written again, and writes to one line leave every other line unchanged.
- R2: The enable register (address 1) stores bit 0 of the write data for the selected line, and a read returns it in bit 0. A disabled line never raises a request.
- R3: The priority register (address 2) stores the priority in bits 3:0. With the secure option on, bit 8 holds a security flag. A write that carries only bits 3:0 clears the flag.
- R4: The trigger-mode register (address 3) stores 0 for level mode and 1 for pulse mode, and a read returns the stored mode of the selected line.
- R5: A level-mode line stays pending while its input is high. It stops being pending two clock edges after the input falls.
- R6: A pulse-mode line latches a pending flag on a rising edge of its synchronised input and keeps it after the input falls. Taking the line clears the flag. A second edge while the flag is set does not queue another request.
- R7: Writing 1 to the cancel register (address 4) clears the pending flag of the selected pulse-mode line. Writing 0 has no effect.
- R8: The request goes to the pending, enabled line with the lowest priority value. A tie goes to the lowest line number. The request output carries the line number and the priority.
- R9: The active register (address 5, low 16 bits) sets bit p when the core takes a line of priority p. A completion pulse clears the lowest set bit. A request is raised only if its priority value is below every set bit.
- R10: After reset every line is disabled, in level mode, not pending and at priority 15, with the security flag clear. The select register and the active register read 0.
- R11: When a new rising edge lands in the same cycle as a cancel or a take for that line, the pending flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | N_LINES | Raw interrupt inputs, asynchronous |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq_req | output | 1 | Request to the core |
| irq_req_id | output | ID_W | Line number of the request |
| irq_req_prio | output | PRIO_W | Priority of the request |
| irq_take | input | 1 | Core enters the handler for irq_take_id |
| irq_take_id | input | ID_W | Line being taken |
| irq_done | input | 1 | Core leaves the most urgent active handler |

## Verification
Two events on one pulse line can fall in the same cycle: a fresh rising edge that sets the flag, and a cancel write or a take that clears it. The bench sets a line's flag with an earlier pulse. It then raises the input again and counts the two synchroniser edges so that the cancel write is latched on exactly the edge where the new rise is seen. The request must still be present afterwards, which shows the new edge was kept.

// File: rtl/irq_cfg_pkg.sv
package irq_cfg_pkg;

   typedef enum logic [2:0] {
      RA_SELECT = 3'd0,
      RA_ENABLE = 3'd1,
      RA_URGENCY = 3'd2,
      RA_MODE   = 3'd3,
      RA_CANCEL = 3'd4,
      RA_ACTIVE = 3'd5
   } reg_addr_e;

   localparam logic MODE_LEVEL = 1'b0;
   localparam logic MODE_PULSE = 1'b1;

   localparam int REG_DATA_W = 32;

endpackage

// File: rtl/irq_line_state.sv
module irq_line_state
   import irq_cfg_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PRIO_W      = 4,
   parameter bit SECURE_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_raw,
   input  logic              wr_enable,
   input  logic              wr_urgency,
   input  logic              wr_mode,
   input  logic              cancel_hit,
   input  logic              take_hit,
   input  logic              wdata_bit0,
   input  logic [PRIO_W-1:0] wdata_prio,
   input  logic              wdata_sec,
   output logic              en_q,
   output logic [PRIO_W-1:0] prio_q,
   output logic              sec_q,
   output logic              mode_q,
   output logic              pend
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_line_state: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   level_now;
   logic                   rise;
   logic                   flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], irq_raw};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign level_now = sync_q[SYNC_STAGES-1];
   assign rise      = level_now & ~last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         prio_q <= '1;
         mode_q <= MODE_LEVEL;
      end else begin
         if (wr_enable)  en_q   <= wdata_bit0;
         if (wr_urgency) prio_q <= wdata_prio;
         if (wr_mode)    mode_q <= wdata_bit0;
      end
   end

   if (SECURE_EN) begin : g_secure
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          sec_q <= 1'b0;
         else if (wr_urgency) sec_q <= wdata_sec;
      end
   end else begin : g_plain
      assign sec_q = 1'b0;
   end

   // A new edge wins over a same-cycle cancel or take.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       flag_q <= 1'b0;
      else if (mode_q == MODE_LEVEL)    flag_q <= 1'b0;
      else if (rise)                    flag_q <= 1'b1;
      else if (cancel_hit || take_hit)  flag_q <= 1'b0;
   end

   assign pend = (mode_q == MODE_PULSE) ? flag_q : level_now;

   p_cancel_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_PULSE && !wr_mode && cancel_hit && !rise) |=> !pend);

   p_take_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_PULSE && !wr_mode && take_hit && !rise) |=> !pend);

   p_edge_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_PULSE && !wr_mode && rise) |=> pend);

endmodule

// File: rtl/irq_active_track.sv
module irq_active_track #(
   parameter int PRIO_W = 4,
   localparam int ACT_W = 1 << PRIO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [PRIO_W-1:0] take_prio,
   input  logic              done,
   output logic [ACT_W-1:0]  active_q
);

   logic [ACT_W-1:0] after_done;
   logic [ACT_W-1:0] active_n;

   always_comb begin
      after_done = done ? (active_q & (active_q - 1'b1)) : active_q;
      active_n   = after_done;
      if (take) active_n[take_prio] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= '0;
      else        active_q <= active_n;
   end

   p_done_drops_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !take && active_q != '0) |=>
         ($countones(active_q) == $countones($past(active_q)) - 1));

   p_take_marks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> active_q[$past(take_prio)]);

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int N_LINES = 16,
   parameter int PRIO_W  = 4,
   localparam int ID_W   = $clog2(N_LINES),
   localparam int ACT_W  = 1 << PRIO_W
) (
   input  logic [N_LINES-1:0]             cand,
   input  logic [N_LINES-1:0][PRIO_W-1:0] prio,
   input  logic [ACT_W-1:0]               active,
   output logic                           req,
   output logic [ID_W-1:0]                req_id,
   output logic [PRIO_W-1:0]              req_prio
);

   logic              found;
   logic [ID_W-1:0]   best_id;
   logic [PRIO_W-1:0] best_p;
   logic [PRIO_W:0]   ceiling;

   always_comb begin
      found   = 1'b0;
      best_id = '0;
      best_p  = '1;
      for (int i = 0; i < N_LINES; i++) begin
         if (cand[i] && (!found || prio[i] < best_p)) begin
            found   = 1'b1;
            best_id = ID_W'(i);
            best_p  = prio[i];
         end
      end
   end

   always_comb begin
      ceiling = (PRIO_W+1)'(ACT_W);
      for (int j = ACT_W - 1; j >= 0; j--) begin
         if (active[j]) ceiling = (PRIO_W+1)'(j);
      end
   end

   assign req      = found && ({1'b0, best_p} < ceiling);
   assign req_id   = best_id;
   assign req_prio = best_p;

endmodule

// File: rtl/irq_cfg_unit.sv
module irq_cfg_unit
   import irq_cfg_pkg::*;
#(
   parameter int N_LINES     = 16,
   parameter int PRIO_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit SECURE_EN   = 1'b1,
   parameter int SEC_BIT     = 8,
   localparam int ID_W       = $clog2(N_LINES),
   localparam int ACT_W      = 1 << PRIO_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_LINES-1:0]    irq_in,
   input  logic [2:0]            reg_addr,
   input  logic                  reg_we,
   input  logic [REG_DATA_W-1:0] reg_wdata,
   output logic [REG_DATA_W-1:0] reg_rdata,
   output logic                  irq_req,
   output logic [ID_W-1:0]       irq_req_id,
   output logic [PRIO_W-1:0]     irq_req_prio,
   input  logic                  irq_take,
   input  logic [ID_W-1:0]       irq_take_id,
   input  logic                  irq_done
);

   if (N_LINES < 2) begin : g_bad_lines
      $error("irq_cfg_unit: N_LINES must be at least 2");
   end
   if (PRIO_W < 1 || PRIO_W > 4) begin : g_bad_prio
      $error("irq_cfg_unit: PRIO_W must be 1 to 4");
   end
   if (SEC_BIT < PRIO_W || SEC_BIT >= REG_DATA_W) begin : g_bad_sec
      $error("irq_cfg_unit: SEC_BIT must lie above the priority field");
   end

   logic [ID_W-1:0]                sel_q;
   logic [N_LINES-1:0]             sel_hit;
   logic [N_LINES-1:0]             en_vec;
   logic [N_LINES-1:0]             sec_vec;
   logic [N_LINES-1:0]             mode_vec;
   logic [N_LINES-1:0]             pend_vec;
   logic [N_LINES-1:0][PRIO_W-1:0] prio_vec;
   logic [ACT_W-1:0]               active_q;
   logic                           wr_sel, wr_en, wr_urg, wr_mode, wr_cancel;
   logic                           take_ok;

   assign wr_sel    = reg_we && reg_addr == RA_SELECT;
   assign wr_en     = reg_we && reg_addr == RA_ENABLE;
   assign wr_urg    = reg_we && reg_addr == RA_URGENCY;
   assign wr_mode   = reg_we && reg_addr == RA_MODE;
   assign wr_cancel = reg_we && reg_addr == RA_CANCEL && reg_wdata[0];
   assign take_ok   = irq_take && (32'(irq_take_id) < N_LINES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= '0;
      else if (wr_sel) sel_q <= reg_wdata[ID_W-1:0];
   end

   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      assign sel_hit[g] = (sel_q == ID_W'(g));

      irq_line_state #(
         .SYNC_STAGES (SYNC_STAGES),
         .PRIO_W      (PRIO_W),
         .SECURE_EN   (SECURE_EN)
      ) line_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .irq_raw    (irq_in[g]),
         .wr_enable  (wr_en && sel_hit[g]),
         .wr_urgency (wr_urg && sel_hit[g]),
         .wr_mode    (wr_mode && sel_hit[g]),
         .cancel_hit (wr_cancel && sel_hit[g]),
         .take_hit   (take_ok && irq_take_id == ID_W'(g)),
         .wdata_bit0 (reg_wdata[0]),
         .wdata_prio (reg_wdata[PRIO_W-1:0]),
         .wdata_sec  (reg_wdata[SEC_BIT]),
         .en_q       (en_vec[g]),
         .prio_q     (prio_vec[g]),
         .sec_q      (sec_vec[g]),
         .mode_q     (mode_vec[g]),
         .pend       (pend_vec[g])
      );
   end

   irq_pick #(
      .N_LINES (N_LINES),
      .PRIO_W  (PRIO_W)
   ) pick_i (
      .cand     (pend_vec & en_vec),
      .prio     (prio_vec),
      .active   (active_q),
      .req      (irq_req),
      .req_id   (irq_req_id),
      .req_prio (irq_req_prio)
   );

   irq_active_track #(
      .PRIO_W (PRIO_W)
   ) act_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take_ok),
      .take_prio (prio_vec[irq_take_id]),
      .done      (irq_done),
      .active_q  (active_q)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_SELECT:  reg_rdata[ID_W-1:0] = sel_q;
         RA_ENABLE:  reg_rdata[0] = en_vec[sel_q];
         RA_URGENCY: begin
            reg_rdata[PRIO_W-1:0] = prio_vec[sel_q];
            reg_rdata[SEC_BIT]    = sec_vec[sel_q];
         end
         RA_MODE:    reg_rdata[0] = mode_vec[sel_q];
         RA_ACTIVE:  reg_rdata[ACT_W-1:0] = active_q;
         default:    reg_rdata = '0;
      endcase
   end

   logic [ACT_W-1:0] urg_mask;
   assign urg_mask = (ACT_W'(2) << irq_req_prio) - 1'b1;

   p_sel_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_sel |=> $stable(sel_q));

   p_enable_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (en_vec[irq_req_id] && pend_vec[irq_req_id]));

   p_req_urgent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ((active_q & urg_mask) == '0));

   p_one_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_hit));

endmodule

// File: tb/irq_cfg_unit_tb_top.sv
module irq_cfg_unit_tb_top;
   import irq_cfg_pkg::*;

   localparam int N  = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_in = '0;
   logic [2:0]    reg_addr = 3'd0;
   logic          reg_we = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          irq_req;
   logic [IW-1:0] irq_req_id;
   logic [3:0]    irq_req_prio;
   logic          irq_take = 1'b0;
   logic [IW-1:0] irq_take_id = '0;
   logic          irq_done = 1'b0;

   int n_chk = 0;
   int n_err = 0;
   int plev [N];

   always #5 clk = ~clk;

   irq_cfg_unit #(.N_LINES(N), .PRIO_W(4), .SYNC_STAGES(2), .SECURE_EN(1'b1), .SEC_BIT(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
      .irq_req_id(irq_req_id), .irq_req_prio(irq_req_prio), .irq_take(irq_take),
      .irq_take_id(irq_take_id), .irq_done(irq_done));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(posedge clk);
      #1 reg_we = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic edges(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic take_line(logic [IW-1:0] id);
      @(negedge clk);
      irq_take = 1'b1; irq_take_id = id;
      @(posedge clk);
      #1 irq_take = 1'b0;
   endtask

   task automatic done_one();
      @(negedge clk);
      irq_done = 1'b1;
      @(posedge clk);
      #1 irq_done = 1'b0;
   endtask

   task automatic req_is(string tag, logic exp_req, int exp_id);
      @(negedge clk);
      chk({tag, " req"}, 32'(irq_req), 32'(exp_req));
      if (exp_req) chk({tag, " id"}, 32'(irq_req_id), 32'(exp_id));
   endtask

   initial begin
      #2_000_000;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R10 reset state
      rd(RA_SELECT, v); chk("R10 select", v, 0);
      rd(RA_ACTIVE, v); chk("R10 active", v, 0);
      for (int i = 0; i < N; i++) begin
         wr(RA_SELECT, i);
         rd(RA_ENABLE, v);  chk("R10 enable", v, 0);
         rd(RA_URGENCY, v); chk("R10 prio", v, 15);
         rd(RA_MODE, v);    chk("R10 mode", v, 0);
      end
      req_is("R10", 1'b0, 0);

      // R1 R2 R3 R4 per-line writes, then read back
      for (int i = 0; i < N; i++) begin
         wr(RA_SELECT, i);
         wr(RA_ENABLE, i & 1);
         wr(RA_MODE, (i >> 1) & 1);
         wr(RA_URGENCY, ((i >> 2) & 1) << 8 | i);
      end
      for (int i = 0; i < N; i++) begin
         wr(RA_SELECT, i);
         rd(RA_SELECT, v);  chk("R1 select", v, i);
         rd(RA_ENABLE, v);  chk("R2 enable", v, i & 1);
         rd(RA_MODE, v);    chk("R4 mode", v, (i >> 1) & 1);
         rd(RA_URGENCY, v); chk("R3 prio+sec", v, ((i >> 2) & 1) << 8 | i);
      end
      wr(RA_SELECT, 5);
      wr(RA_URGENCY, 32'h107);
      rd(RA_URGENCY, v); chk("R3 secure set", v, 32'h107);
      wr(RA_URGENCY, 32'h7);
      rd(RA_URGENCY, v); chk("R3 secure cleared", v, 32'h7);

      // R8 sweep: all level, enabled, prio (3i mod 5)
      for (int i = 0; i < N; i++) begin
         plev[i] = (i * 3) % 5;
         wr(RA_SELECT, i);
         wr(RA_ENABLE, 1);
         wr(RA_MODE, 0);
         wr(RA_URGENCY, plev[i]);
      end
      for (int m = 1; m < (1 << N); m++) begin
         int bi; int bp;
         bi = -1; bp = 99;
         for (int i = 0; i < N; i++)
            if (m[i] && plev[i] < bp) begin bi = i; bp = plev[i]; end
         @(negedge clk);
         irq_in = N'(m);
         edges(3);
         chk("R8 sweep req", 32'(irq_req), 1);
         chk("R8 sweep id", 32'(irq_req_id), bi);
         chk("R8 sweep prio", 32'(irq_req_prio), bp);
      end

      // R5 level follows input
      @(negedge clk); irq_in = 8'h04;
      edges(3);
      req_is("R5 asserted", 1'b1, 2);
      irq_in = 8'h00;
      @(posedge clk);
      req_is("R5 one edge after drop", 1'b1, 2);
      edges(1);
      req_is("R5 two edges after drop", 1'b0, 0);

      // R2 disable gates
      wr(RA_SELECT, 0); wr(RA_ENABLE, 0);
      @(negedge clk); irq_in = 8'h01;
      edges(3);
      req_is("R2 disabled line", 1'b0, 0);
      @(negedge clk); irq_in = 8'h03;
      edges(3);
      req_is("R2 other line", 1'b1, 1);
      @(negedge clk); irq_in = 8'h00;
      edges(3);

      // R6 pulse mode on line 3 alone
      for (int i = 0; i < N; i++) begin
         wr(RA_SELECT, i); wr(RA_ENABLE, 0);
      end
      wr(RA_SELECT, 3); wr(RA_MODE, 1); wr(RA_URGENCY, 2); wr(RA_ENABLE, 1);
      @(negedge clk); irq_in[3] = 1'b1;
      edges(4);
      req_is("R6 pulse latched", 1'b1, 3);
      chk("R6 prio", 32'(irq_req_prio), 2);
      irq_in[3] = 1'b0;
      edges(4);
      req_is("R6 held after fall", 1'b1, 3);
      take_line(3);
      req_is("R6 cleared by take", 1'b0, 0);
      rd(RA_ACTIVE, v); chk("R9 active after take", v, 32'h4);

      // R9 blocking by active level
      wr(RA_SELECT, 1); wr(RA_MODE, 0); wr(RA_URGENCY, 2); wr(RA_ENABLE, 1);
      @(negedge clk); irq_in[1] = 1'b1;
      edges(3);
      req_is("R9 equal level blocked", 1'b0, 0);
      wr(RA_URGENCY, 1);
      req_is("R9 more urgent passes", 1'b1, 1);
      take_line(1);
      rd(RA_ACTIVE, v); chk("R9 nested active", v, 32'h6);
      done_one();
      rd(RA_ACTIVE, v); chk("R9 done clears lowest", v, 32'h4);
      done_one();
      rd(RA_ACTIVE, v); chk("R9 done to idle", v, 0);
      @(negedge clk); irq_in[1] = 1'b0;
      wr(RA_ENABLE, 0);
      wr(RA_SELECT, 3);
      edges(3);

      // R6 no queueing of a second edge
      @(negedge clk); irq_in[3] = 1'b1; edges(3);
      irq_in[3] = 1'b0; edges(3);
      irq_in[3] = 1'b1; edges(3);
      irq_in[3] = 1'b0; edges(3);
      take_line(3);
      done_one();
      req_is("R6 no second request", 1'b0, 0);

      // R7 cancel
      @(negedge clk); irq_in[3] = 1'b1; edges(3);
      irq_in[3] = 1'b0; edges(3);
      req_is("R7 pending before cancel", 1'b1, 3);
      wr(RA_CANCEL, 0);
      req_is("R7 cancel 0 ignored", 1'b1, 3);
      wr(RA_CANCEL, 1);
      req_is("R7 cancel 1 clears", 1'b0, 0);

      // R11 new edge in the cancel cycle
      @(negedge clk); irq_in[3] = 1'b1; edges(3);
      irq_in[3] = 1'b0; edges(3);
      req_is("R11 flag preset", 1'b1, 3);
      @(negedge clk); irq_in[3] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      wr(RA_CANCEL, 1);
      req_is("R11 edge beats cancel", 1'b1, 3);
      irq_in[3] = 1'b0;
      edges(3);
      wr(RA_CANCEL, 1);
      req_is("R11 later cancel clears", 1'b0, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule